// File: doc/BRIEF.md
# Max-Log-MAP Trellis Step Unit

This block performs one trellis stage of a Max-Log-MAP soft decoder for an eight-state, rate-1/3 recursive systematic constituent code. It is called once per stage by an outside controller. In forward mode it takes the eight alpha metrics of stage k-1. In backward mode it takes the eight beta metrics of stage k+1. In both modes it also takes the soft systematic value V (channel value plus extrinsic) and the soft parity value Lz, and it returns the eight metrics of the adjacent stage. Those metrics are normalised so that state 0 reads zero.

In LLR mode the unit combines the alpha vector on its metric input, the branch metrics and a beta vector read from outside storage. It returns one soft decision for the stage. A start flag replaces the metric input with the recursion seed, which lets the controller open a forward or backward pass without building that vector itself. All results are registered, so they appear one clock after the inputs are accepted. Beta storage, windowing and iteration control belong to the surrounding decoder.

Top module: `maxlog_trellis_step`

## Requirements
- R1: While rst_n is low and after its release, out_valid is 0 and every metric_out slot and llr_out are 0 until the first accepted input.
- R2: An input is accepted on a rising edge with in_valid high. Its results and out_valid=1 appear after exactly that edge, and out_valid is 0 after an edge with in_valid low.
- R3: State s = 4*r1 + 2*r2 + r3, where r1 is the newest register bit. For input bit u, feedback a = u^r2^r3, parity p = a^r1^r3, and next state = 4*a + 2*r1 + r2. The branch metric is 0, V, Lz or sat(V+Lz) for (u,p) = (0,0), (1,0), (0,1), (1,1).
- R4: With mode = 0 (forward), raw[j] = the maximum over both branches s→j of sat(metric[s] + gamma).
- R5: With mode = 1 (backward), raw[s] = the maximum over u of sat(metric[next(s,u)] + gamma(s,u)).
- R6: In modes 0 and 1, metric_out slot i = sat(raw[i] − raw[0]). Slot 0 is therefore 0. Slot i occupies bits [i*W +: W].
- R7: When start is 1, the metric input is replaced by the seed: slot 0 = 0 and slots 1..7 = −2^(W−1). beta_in is never seeded.
- R8: Every two-operand addition or subtraction saturates to [−2^(W−1), 2^(W−1)−1]. The default is W = 10 (sign, 6 integer bits, 3 fraction bits).
- R9: With mode = 2 (LLR), llr_out = sat(M1 − M0). Mu is the maximum of sat(sat(alpha[s] + gamma) + beta_in[next]) over the branches with input bit u. metric_out keeps its value.
- R10: Modes 0 and 1 leave llr_out unchanged. Mode 3 (idle) leaves both metric_out and llr_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stage inputs are valid |
| mode | input | 2 | 0 forward, 1 backward, 2 LLR, 3 idle |
| start | input | 1 | Use recursion seed instead of metric_in |
| metric_in | input | 8*W | Alpha or beta vector, slot i at [i*W +: W] |
| beta_in | input | 8*W | Beta vector for LLR mode |
| sys_v | input | W | Systematic plus extrinsic soft value |
| par_z | input | W | Parity soft value |
| out_valid | output | 1 | Results updated this cycle |
| metric_out | output | 8*W | Normalised next-stage metrics |
| llr_out | output | W | Output soft decision |

## Verification
On every cycle the assertions check four things: the one-cycle valid latency, that state 0 leaves zero after any forward or backward step, that LLR mode leaves the metric register untouched, and that the ACS and idle modes leave the LLR register untouched. The arithmetic itself can only be shown by the bench's scenarios. Those scenarios cover the trellis connectivity, the branch-metric selection, saturation at both rails, the effect of the start seed and the exact LLR values, all compared against a behavioural trellis model. They include chained forward and backward passes, random vectors in every mode, and directed vectors at the most positive and most negative soft values.

// File: rtl/maxlog_trellis_step.sv
module maxlog_trellis_step #(
  parameter int W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [1:0]     mode,
  input  logic           start,
  input  logic [8*W-1:0] metric_in,
  input  logic [8*W-1:0] beta_in,
  input  logic [W-1:0]   sys_v,
  input  logic [W-1:0]   par_z,
  output logic           out_valid,
  output logic [8*W-1:0] metric_out,
  output logic [W-1:0]   llr_out
);
  localparam int NS = 8;
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] sat(input logic signed [W:0] x);
    if (x > $signed({MAXV[W-1], MAXV})) return MAXV;
    if (x < $signed({MINV[W-1], MINV})) return MINV;
    return x[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] sadd(input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    return sat({a[W-1], a} + {b[W-1], b});
  endfunction

  function automatic logic signed [W-1:0] ssub(input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    return sat({a[W-1], a} - {b[W-1], b});
  endfunction

  function automatic logic [2:0] nxt(input logic [2:0] s, input logic u);
    logic a;
    a = u ^ s[1] ^ s[0];
    return {a, s[2], s[1]};
  endfunction

  function automatic logic par(input logic [2:0] s, input logic u);
    return u ^ s[1] ^ s[0] ^ s[2] ^ s[0];
  endfunction

  logic signed [W-1:0] g_v, g_z, g_vz;
  assign g_v  = sys_v;
  assign g_z  = par_z;
  assign g_vz = sadd(g_v, g_z);

  function automatic logic signed [W-1:0] gam(input logic u, input logic p,
      input logic signed [W-1:0] v, input logic signed [W-1:0] z, input logic signed [W-1:0] vz);
    case ({u, p})
      2'b00:   return '0;
      2'b10:   return v;
      2'b01:   return z;
      default: return vz;
    endcase
  endfunction

  logic signed [W-1:0] m_in [NS];
  logic signed [W-1:0] b_in [NS];
  logic signed [W-1:0] raw  [NS];
  logic signed [W-1:0] nrm  [NS];
  logic signed [W-1:0] m1, m0, llr_n;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      m_in[i] = start ? ((i == 0) ? '0 : MINV) : metric_in[i*W +: W];
      b_in[i] = beta_in[i*W +: W];
      raw[i]  = MINV;
    end
    m1 = MINV;
    m0 = MINV;
    for (int s = 0; s < NS; s++) begin
      for (int u = 0; u < 2; u++) begin
        logic [2:0] ns;
        logic signed [W-1:0] g, c;
        ns = nxt(3'(s), u[0]);
        g  = gam(u[0], par(3'(s), u[0]), g_v, g_z, g_vz);
        if (mode[0]) begin
          c = sadd(m_in[ns], g);
          if (c > raw[s]) raw[s] = c;
        end else begin
          c = sadd(m_in[s], g);
          if (c > raw[ns]) raw[ns] = c;
        end
        c = sadd(sadd(m_in[s], g), b_in[ns]);
        if (u == 1) begin
          if (c > m1) m1 = c;
        end else begin
          if (c > m0) m0 = c;
        end
      end
    end
    for (int i = 0; i < NS; i++) nrm[i] = ssub(raw[i], raw[0]);
    llr_n = ssub(m1, m0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      metric_out <= '0;
      llr_out    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid && !mode[1])
        for (int i = 0; i < NS; i++) metric_out[i*W +: W] <= nrm[i];
      if (in_valid && mode == 2'd2)
        llr_out <= llr_n;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid)); // R2

  AST_NORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mode[1] |=> metric_out[W-1:0] == '0); // R6

  AST_LLR_KEEPS_METRIC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode[1] |=> $stable(metric_out)); // R9

  AST_ACS_KEEPS_LLR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode != 2'd2 |=> $stable(llr_out)); // R10
endmodule

// File: tb/maxlog_trellis_step_bench.sv
module maxlog_trellis_step_bench;
  localparam int W = 10;
  localparam int HI = (1 << (W-1)) - 1;
  localparam int LO = -(1 << (W-1));

  typedef struct {
    logic [8*W-1:0] m;
    logic [W-1:0]   l;
    string          tag;
  } exp_t;

  logic clk = 0, rst_n = 0, in_valid = 0, start = 0;
  logic [1:0] mode = 0;
  logic [8*W-1:0] metric_in = '0, beta_in = '0, metric_out;
  logic [W-1:0] sys_v = '0, par_z = '0, llr_out;
  logic out_valid;
  int checks = 0, fails = 0;
  bit finished = 0;
  exp_t q[$];
  logic [8*W-1:0] ref_m = '0;
  logic [W-1:0]   ref_l = '0;

  always #2 clk = ~clk;

  maxlog_trellis_step #(.W(W)) u_maxlog_trellis_step (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .start(start),
    .metric_in(metric_in), .beta_in(beta_in), .sys_v(sys_v), .par_z(par_z),
    .out_valid(out_valid), .metric_out(metric_out), .llr_out(llr_out));

  function automatic int clip(int x);
    return (x > HI) ? HI : (x < LO) ? LO : x;
  endfunction

  function automatic int slot(logic [8*W-1:0] v, int i);
    logic signed [W-1:0] t;
    t = v[i*W +: W];
    return int'(t);
  endfunction

  task automatic check(string tag, logic [8*W-1:0] am, logic [8*W-1:0] em,
                       logic [W-1:0] al, logic [W-1:0] el);
    checks++;
    if (am !== em || al !== el) begin
      fails++;
      $display("FAIL %s metric=%h llr=%h expected metric=%h llr=%h", tag, am, al, em, el);
    end
  endtask

  task automatic step(int md, bit st, logic [8*W-1:0] mi, logic [8*W-1:0] bi,
                      int v, int z, string tag);
    int m[8], b[8], raw[8];
    int mx1, mx0;
    exp_t e;
    for (int i = 0; i < 8; i++) begin
      m[i] = st ? ((i == 0) ? 0 : LO) : slot(mi, i);
      b[i] = slot(bi, i);
      raw[i] = LO;
    end
    mx1 = LO; mx0 = LO;
    for (int s = 0; s < 8; s++) begin
      for (int u = 0; u < 2; u++) begin
        int r1, r2, r3, fb, p, n, g, c;
        r1 = (s >> 2) & 1; r2 = (s >> 1) & 1; r3 = s & 1;
        fb = u ^ r2 ^ r3;
        p  = fb ^ r1 ^ r3;
        n  = fb * 4 + r1 * 2 + r2;
        g  = (u ? v : 0);
        g  = p ? (u ? clip(v + z) : z) : g;
        if (md == 0) raw[n] = (clip(m[s] + g) > raw[n]) ? clip(m[s] + g) : raw[n];
        if (md == 1) raw[s] = (clip(m[n] + g) > raw[s]) ? clip(m[n] + g) : raw[s];
        c = clip(clip(m[s] + g) + b[n]);
        if (u == 1 && c > mx1) mx1 = c;
        if (u == 0 && c > mx0) mx0 = c;
      end
    end
    if (md < 2)
      for (int i = 0; i < 8; i++) ref_m[i*W +: W] = W'(clip(raw[i] - raw[0]));
    if (md == 2) ref_l = W'(clip(mx1 - mx0));
    e.m = ref_m; e.l = ref_l; e.tag = tag;
    q.push_back(e);
    mode = 2'(md); start = st; metric_in = mi; beta_in = bi;
    sys_v = W'(v); par_z = W'(z); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [8*W-1:0] rvec();
    logic [8*W-1:0] r;
    for (int i = 0; i < 8; i++) r[i*W +: W] = W'($urandom);
    return r;
  endfunction

  function automatic int rsoft();
    logic signed [W-1:0] t;
    t = W'($urandom);
    return int'(t);
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected out_valid");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, metric_out, e.m, llr_out, e.l);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8*W-1:0] mx, mn, ones;
    repeat (3) @(negedge clk);
    check("R1 reset", metric_out, '0, llr_out, '0);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R1 out_valid=%b expected 0", out_valid); end
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", metric_out, '0, llr_out, '0);

    step(0, 1, rvec(), '0, 24, -13, "R7 R4 forward seed");
    for (int k = 0; k < 10; k++) step(0, 0, ref_m, '0, rsoft(), rsoft(), "R3 R4 forward chain");
    step(1, 1, rvec(), '0, -40, 17, "R7 R5 backward seed");
    for (int k = 0; k < 10; k++) step(1, 0, ref_m, '0, rsoft(), rsoft(), "R5 R6 backward chain");
    checks++;
    @(negedge clk);
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R2 out_valid=%b expected 0 after idle edge", out_valid); end

    step(2, 0, rvec(), rvec(), 33, -7, "R9 llr");
    step(2, 1, rvec(), rvec(), -100, 55, "R9 R7 llr seeded alpha");
    step(3, 0, rvec(), rvec(), 5, 5, "R10 idle holds");
    step(0, 0, rvec(), rvec(), 9, 3, "R10 forward keeps llr");
    step(2, 0, rvec(), rvec(), 1, 2, "R9 llr keeps metric");

    for (int i = 0; i < 8; i++) begin
      mx[i*W +: W] = W'(HI); mn[i*W +: W] = W'(LO);
      ones[i*W +: W] = (i % 2) ? W'(HI) : W'(LO);
    end
    step(0, 1, '0, '0, HI, HI, "R8 positive rail forward");
    step(0, 0, mn, '0, LO, LO, "R8 negative rail forward");
    step(1, 0, ones, '0, HI, LO, "R8 mixed rail backward");
    step(0, 0, ones, '0, LO, HI, "R8 R6 normalise saturation");
    step(2, 0, mx, mx, HI, HI, "R8 llr positive rail");
    step(2, 0, ones, mn, LO, HI, "R8 llr mixed rail");

    for (int k = 0; k < 300; k++)
      step(int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), rvec(), rvec(),
           rsoft(), rsoft(), "R3 R4 R5 R9 random");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin fails++; $display("FAIL R2 %0d results missing expected 0", q.size()); end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule